// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches while the branch instruction sits in the decode stage of a five-stage pipeline. It receives the one register operand read in decode and a small branch-kind code, and tests that operand against zero. The four tests are equal to zero, not equal to zero, negative, and strictly positive, and none of them needs a subtractor. Alongside, a dedicated adder forms the taken target from the branch's own incremented PC and its 16-bit word displacement. The block then steers the fetch stage's next address.

The architecture defines exactly one delay slot. When the branch is in decode, the instruction after it is already being fetched, and that instruction always executes. The redirect therefore goes to the fetch that follows the slot. The not-taken address is the fetch stage's own incremented PC, which is passed in unchanged. A taken branch costs one slot, not three squashed instructions. A branch found in the slot position is treated as a plain instruction.

There is no forwarding into decode. If the instruction directly ahead, now in execute, writes the branch's source register, the block raises a one-cycle stall request and resolves the branch on the following cycle.

Top module: `br_resolve_unit`

## Requirements
- R1: During and right after reset, `delaySlotNow` and `stallReq` are 0, and with `idValid` low `brTaken` and `nextPcSel` are 0.
- R2: Kind code 3'd1 (equal-to-zero) is taken exactly when every bit of `brOperand` is 0.
- R3: Kind code 3'd2 (not-equal-to-zero) is taken exactly when at least one bit of `brOperand` is 1.
- R4: Kind code 3'd3 (less-than-zero) is taken exactly when the top bit of `brOperand` (bit DATA_W-1) is 1.
- R5: Kind code 3'd4 (greater-than-zero) is taken exactly when the top bit is 0 and the operand is not zero.
- R6: Kind codes 3'd0, 3'd5, 3'd6 and 3'd7, and any cycle with `idValid` low, give `brTaken`=0, `nextPcSel`=0, `stallReq`=0 and `nextPc`=`ifPcPlus4`.
- R7: `brTarget` always equals `idPcPlus4` plus the sign-extended `brDisp` multiplied by 4, modulo 2^ADDR_W.
- R8: In the same cycle as a taken branch, `nextPcSel`=1 and `nextPc`=`brTarget`. Otherwise `nextPcSel`=0 and `nextPc`=`ifPcPlus4`.
- R9: After a branch resolves (taken or not), `delaySlotNow` is 1 from the next cycle. It stays at 1 through cycles with `idValid` low, and it clears after the first cycle with `idValid` high. A branch decoded while `delaySlotNow`=1 is neither taken nor stalled.
- R10: If a branch kind (1 to 4) is valid outside the slot, `exWrEn`=1, `exWrReg`=`brSrcReg` and `brSrcReg`≠0, then `stallReq`=1 with `brTaken`=0 and `nextPcSel`=0.
- R11: `stallReq` never stays high for two consecutive cycles. The held branch resolves on the cycle after the stall.
- R12: A source register of 0 never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idValid | input | 1 | A real instruction occupies decode |
| brKind | input | 3 | Branch-kind code of the decode instruction |
| brSrcReg | input | REG_W | Index of the register tested |
| brOperand | input | DATA_W | Value of that register read in decode |
| brDisp | input | DISP_W | Signed word displacement |
| idPcPlus4 | input | ADDR_W | Incremented PC of the branch |
| ifPcPlus4 | input | ADDR_W | Incremented PC of the fetch stage |
| exWrEn | input | 1 | Instruction in execute writes a register |
| exWrReg | input | REG_W | Register that instruction writes |
| brTaken | output | 1 | Branch resolved and taken this cycle |
| brTarget | output | ADDR_W | Taken target address |
| nextPcSel | output | 1 | 1 selects the target for the next fetch |
| nextPc | output | ADDR_W | Next fetch address |
| stallReq | output | 1 | Hold fetch and decode for one cycle |
| delaySlotNow | output | 1 | The decode instruction is a delay slot |

## Verification
The bench builds the block with DATA_W=16 and ADDR_W=24, so the operand's top bit sits at bit 15. This brings the sign-bit boundaries 0x7FFF, 0x8000 and 0x8001 within reach with short literals. With a 24-bit address, a target computed from a PC near 0xFFFFF0 wraps past the top of the address space. A 24-bit address is also wider than the shifted displacement, which exercises the sign-extension path for displacements that point backwards.

// File: rtl/br_pkg.sv
package br_pkg;

  // Branch-kind codes seen on brKind; any other value is not a branch
  localparam logic [2:0] KIND_NONE = 3'd0;
  localparam logic [2:0] KIND_EQZ  = 3'd1;
  localparam logic [2:0] KIND_NEZ  = 3'd2;
  localparam logic [2:0] KIND_LTZ  = 3'd3;
  localparam logic [2:0] KIND_GTZ  = 3'd4;

  // Slot-tracking state of the control
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HELD = 2'd1,
    ST_SLOT = 2'd2
  } brState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic selTarget;  // steer the next fetch to the target
    logic resolveNow; // a branch is being resolved this cycle
  } brStrobe_t;

  function automatic logic isBranchKind(input logic [2:0] k);
    return (k == KIND_EQZ) || (k == KIND_NEZ) ||
           (k == KIND_LTZ) || (k == KIND_GTZ);
  endfunction

endpackage

// File: rtl/br_datapath.sv
module br_datapath
  import br_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [2:0]        brKind,
  input  logic [DATA_W-1:0] brOperand,
  input  logic [DISP_W-1:0] brDisp,
  input  logic [ADDR_W-1:0] idPcPlus4,
  input  logic [ADDR_W-1:0] ifPcPlus4,
  input  brStrobe_t         strobe,
  output logic              condMet,
  output logic [ADDR_W-1:0] brTarget,
  output logic [ADDR_W-1:0] nextPc
);

  localparam int OFS_W = DISP_W + 2; // width of the byte offset

  logic isZero;
  logic isNeg;
  logic [ADDR_W-1:0] byteOfs;

  // Zero and sign tests on one operand: no subtractor
  assign isZero = ~|brOperand;
  assign isNeg  = brOperand[DATA_W-1];

  always_comb begin
    unique case (brKind)
      KIND_EQZ: condMet = isZero;
      KIND_NEZ: condMet = ~isZero;
      KIND_LTZ: condMet = isNeg;
      KIND_GTZ: condMet = ~isNeg & ~isZero;
      default:  condMet = 1'b0;
    endcase
  end

  // Word displacement to byte offset, widened or cut to the address width
  generate
    if (ADDR_W > OFS_W) begin : g_sext
      assign byteOfs = {{(ADDR_W-OFS_W){brDisp[DISP_W-1]}}, brDisp, 2'b00};
    end else begin : g_trunc
      logic [OFS_W-1:0] fullOfs;
      assign fullOfs = {brDisp, 2'b00};
      assign byteOfs = fullOfs[ADDR_W-1:0];
    end
  endgenerate

  // Dedicated target adder in decode
  assign brTarget = idPcPlus4 + byteOfs;

  // Next-fetch select: sequential path comes straight from fetch
  assign nextPc = strobe.selTarget ? brTarget : ifPcPlus4;

endmodule

// File: rtl/br_control.sv
module br_control
  import br_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idValid,
  input  logic [2:0]       brKind,
  input  logic [REG_W-1:0] brSrcReg,
  input  logic             exWrEn,
  input  logic [REG_W-1:0] exWrReg,
  input  logic             condMet,
  output brStrobe_t        strobe,
  output logic             stallReq,
  output logic             delaySlotNow
);

  brState_e state, stateNxt;
  logic validBranch;
  logic depHit;
  logic hazard;
  logic resolve;

  assign validBranch = idValid && isBranchKind(brKind);
  assign depHit      = exWrEn && (exWrReg == brSrcReg) && (brSrcReg != '0);

  // A held branch (ST_HELD) is never stalled a second time
  assign hazard  = validBranch && (state == ST_RUN) && depHit;
  assign resolve = validBranch && (state != ST_SLOT) && !hazard;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_RUN: begin
        if (hazard)       stateNxt = ST_HELD;
        else if (resolve) stateNxt = ST_SLOT;
      end
      ST_HELD: begin
        if (resolve)      stateNxt = ST_SLOT;
        else              stateNxt = ST_RUN;
      end
      ST_SLOT: begin
        if (idValid)      stateNxt = ST_RUN;
      end
      default:            stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  assign strobe.resolveNow = resolve;
  assign strobe.selTarget  = resolve && condMet;
  assign stallReq          = hazard;
  assign delaySlotNow      = (state == ST_SLOT);

endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
  import br_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idValid,
  input  logic [2:0]        brKind,
  input  logic [REG_W-1:0]  brSrcReg,
  input  logic [DATA_W-1:0] brOperand,
  input  logic [DISP_W-1:0] brDisp,
  input  logic [ADDR_W-1:0] idPcPlus4,
  input  logic [ADDR_W-1:0] ifPcPlus4,
  input  logic              exWrEn,
  input  logic [REG_W-1:0]  exWrReg,
  output logic              brTaken,
  output logic [ADDR_W-1:0] brTarget,
  output logic              nextPcSel,
  output logic [ADDR_W-1:0] nextPc,
  output logic              stallReq,
  output logic              delaySlotNow
);

  brStrobe_t strobe;
  logic      condMet;

  br_control #(.REG_W(REG_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .idValid      (idValid),
    .brKind       (brKind),
    .brSrcReg     (brSrcReg),
    .exWrEn       (exWrEn),
    .exWrReg      (exWrReg),
    .condMet      (condMet),
    .strobe       (strobe),
    .stallReq     (stallReq),
    .delaySlotNow (delaySlotNow)
  );

  br_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_dp (
    .brKind    (brKind),
    .brOperand (brOperand),
    .brDisp    (brDisp),
    .idPcPlus4 (idPcPlus4),
    .ifPcPlus4 (ifPcPlus4),
    .strobe    (strobe),
    .condMet   (condMet),
    .brTarget  (brTarget),
    .nextPc    (nextPc)
  );

  assign brTaken   = strobe.selTarget;
  assign nextPcSel = strobe.selTarget;

endmodule

// File: rtl/br_resolve_checker.sv
module br_resolve_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              idValid,
  input logic [2:0]        brKind,
  input logic [REG_W-1:0]  brSrcReg,
  input logic [DATA_W-1:0] brOperand,
  input logic [ADDR_W-1:0] ifPcPlus4,
  input logic              brTaken,
  input logic              nextPcSel,
  input logic [ADDR_W-1:0] nextPc,
  input logic              stallReq,
  input logic              delaySlotNow
);

  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |=> !stallReq); // R11

  AST_STALL_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |-> (!brTaken && !nextPcSel)); // R10

  AST_SLOT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    brTaken |=> delaySlotNow); // R9

  AST_SLOT_NO_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    delaySlotNow |-> (!brTaken && !stallReq)); // R9

  AST_REG0_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (brSrcReg == '0) |-> !stallReq); // R12

  AST_IDLE_SEQ_PC: assert property (@(posedge clk) disable iff (!rstN)
    !idValid |-> (!brTaken && nextPc == ifPcPlus4)); // R6

  AST_EQZ_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (idValid && brKind == 3'd1 && brOperand == '0 && !stallReq && !delaySlotNow)
      |-> brTaken); // R2

endmodule

bind br_resolve_unit br_resolve_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .idValid      (idValid),
  .brKind       (brKind),
  .brSrcReg     (brSrcReg),
  .brOperand    (brOperand),
  .ifPcPlus4    (ifPcPlus4),
  .brTaken      (brTaken),
  .nextPcSel    (nextPcSel),
  .nextPc       (nextPc),
  .stallReq     (stallReq),
  .delaySlotNow (delaySlotNow)
);

// File: tb/sim_br_resolve_unit.sv
module sim_br_resolve_unit;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 24;
  localparam int DISP_W = 16;
  localparam int REG_W  = 5;

  logic              clk = 1'b0;
  logic              rstN;
  logic              idValid;
  logic [2:0]        brKind;
  logic [REG_W-1:0]  brSrcReg;
  logic [DATA_W-1:0] brOperand;
  logic [DISP_W-1:0] brDisp;
  logic [ADDR_W-1:0] idPcPlus4;
  logic [ADDR_W-1:0] ifPcPlus4;
  logic              exWrEn;
  logic [REG_W-1:0]  exWrReg;
  logic              brTaken;
  logic [ADDR_W-1:0] brTarget;
  logic              nextPcSel;
  logic [ADDR_W-1:0] nextPc;
  logic              stallReq;
  logic              delaySlotNow;

  always #(CLK_PERIOD/2) clk = ~clk;

  br_resolve_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W), .REG_W(REG_W)) u0 (
    .clk(clk), .rstN(rstN), .idValid(idValid), .brKind(brKind), .brSrcReg(brSrcReg),
    .brOperand(brOperand), .brDisp(brDisp), .idPcPlus4(idPcPlus4), .ifPcPlus4(ifPcPlus4),
    .exWrEn(exWrEn), .exWrReg(exWrReg), .brTaken(brTaken), .brTarget(brTarget),
    .nextPcSel(nextPcSel), .nextPc(nextPc), .stallReq(stallReq), .delaySlotNow(delaySlotNow)
  );

  typedef struct {
    string             req;
    logic              taken;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] npc;
    logic              stall;
    logic              slot;
  } expItem_t;

  expItem_t sbQ[$];
  int checks = 0;
  int errors = 0;
  logic mSlot = 1'b0;
  logic mHeld = 1'b0;
  logic done = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: apply one decode cycle and push the expected outputs
  task automatic step(input string req, input logic v, input logic [2:0] k,
                      input logic [REG_W-1:0] src, input logic [DATA_W-1:0] op,
                      input logic [DISP_W-1:0] d, input logic [ADDR_W-1:0] idPc,
                      input logic [ADDR_W-1:0] ifPc, input logic we,
                      input logic [REG_W-1:0] wr);
    expItem_t e;
    logic isBr, cond, hz, res;
    logic signed [31:0] sd;
    @(negedge clk);
    idValid = v; brKind = k; brSrcReg = src; brOperand = op; brDisp = d;
    idPcPlus4 = idPc; ifPcPlus4 = ifPc; exWrEn = we; exWrReg = wr;
    isBr = v && (k >= 3'd1) && (k <= 3'd4);
    case (k)
      3'd1: cond = (op == 0);
      3'd2: cond = (op != 0);
      3'd3: cond = op[DATA_W-1];
      3'd4: cond = !op[DATA_W-1] && (op != 0);
      default: cond = 1'b0;
    endcase
    hz  = isBr && !mSlot && !mHeld && we && (wr == src) && (src != 0);
    res = isBr && !mSlot && !hz;
    sd  = {{(32-DISP_W){d[DISP_W-1]}}, d};
    e.req    = req;
    e.taken  = res && cond;
    e.target = ADDR_W'(32'(idPc) + (sd <<< 2));
    e.npc    = e.taken ? e.target : ifPc;
    e.stall  = hz;
    e.slot   = mSlot;
    sbQ.push_back(e);
    mHeld = hz;
    mSlot = res ? 1'b1 : (v ? 1'b0 : mSlot);
  endtask

  // Monitor: compare between edges
  always @(negedge clk) begin
    #2;
    if (sbQ.size() > 0) begin
      expItem_t e;
      e = sbQ.pop_front();
      chk(e.req, "brTaken",      32'(brTaken),      32'(e.taken));
      chk(e.req, "nextPcSel",    32'(nextPcSel),    32'(e.taken));
      chk(e.req, "nextPc",       32'(nextPc),       32'(e.npc));
      chk(e.req, "brTarget",     32'(brTarget),     32'(e.target));
      chk(e.req, "stallReq",     32'(stallReq),     32'(e.stall));
      chk(e.req, "delaySlotNow", 32'(delaySlotNow), 32'(e.slot));
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; idValid = 1'b0; brKind = 3'd0; brSrcReg = '0; brOperand = '0;
    brDisp = '0; idPcPlus4 = '0; ifPcPlus4 = 24'h000004; exWrEn = 1'b0; exWrReg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "delaySlotNow in reset", 32'(delaySlotNow), 0);
    chk("R1", "stallReq in reset", 32'(stallReq), 0);
    chk("R1", "brTaken in reset", 32'(brTaken), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "delaySlotNow after reset", 32'(delaySlotNow), 0);
    chk("R1", "nextPcSel after reset", 32'(nextPcSel), 0);

    // R6: plain instruction, bubble, unused kinds
    step("R6", 1, 3'd0, 5'd1, 16'h0000, 16'h0004, 24'h000100, 24'h000104, 0, 0);
    step("R6", 0, 3'd1, 5'd1, 16'h0000, 16'h0004, 24'h000104, 24'h000108, 0, 0);
    step("R6", 1, 3'd5, 5'd1, 16'h0000, 16'h0010, 24'h000108, 24'h00010C, 0, 0);
    step("R6", 1, 3'd6, 5'd2, 16'h8000, 16'h0010, 24'h00010C, 24'h000110, 0, 0);
    step("R6", 1, 3'd7, 5'd3, 16'h0001, 16'h0010, 24'h000110, 24'h000114, 0, 0);

    // R2 R7 R8: equal-to-zero taken, then its delay slot (R9)
    step("R2", 1, 3'd1, 5'd4, 16'h0000, 16'h0010, 24'h000200, 24'h000204, 0, 0);
    step("R9", 1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h000204, 24'h000208, 0, 0);
    step("R2", 1, 3'd1, 5'd4, 16'h0100, 16'h0010, 24'h000208, 24'h00020C, 0, 0);
    // R9: branch in the slot is ignored
    step("R9", 1, 3'd2, 5'd4, 16'h0100, 16'h0020, 24'h00020C, 24'h000210, 0, 0);

    // R3
    step("R3", 1, 3'd2, 5'd6, 16'h0001, 16'h0003, 24'h000300, 24'h000304, 0, 0);
    step("R9", 1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h000304, 24'h000308, 0, 0);
    step("R3", 1, 3'd2, 5'd6, 16'h0000, 16'h0003, 24'h000308, 24'h00030C, 0, 0);
    step("R9", 1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h00030C, 24'h000310, 0, 0);

    // R4: sign-bit boundaries
    step("R4", 1, 3'd3, 5'd7, 16'h8000, 16'h0008, 24'h000400, 24'h000404, 0, 0);
    step("R9", 1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h000404, 24'h000408, 0, 0);
    step("R4", 1, 3'd3, 5'd7, 16'h7FFF, 16'h0008, 24'h000408, 24'h00040C, 0, 0);
    step("R9", 1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h00040C, 24'h000410, 0, 0);
    step("R4", 1, 3'd3, 5'd7, 16'h0000, 16'h0008, 24'h000410, 24'h000414, 0, 0);
    step("R9", 1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h000414, 24'h000418, 0, 0);

    // R5
    step("R5", 1, 3'd4, 5'd8, 16'h0001, 16'h0002, 24'h000500, 24'h000504, 0, 0);
    step("R9", 1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h000504, 24'h000508, 0, 0);
    step("R5", 1, 3'd4, 5'd8, 16'h0000, 16'h0002, 24'h000508, 24'h00050C, 0, 0);
    step("R9", 1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h00050C, 24'h000510, 0, 0);
    step("R5", 1, 3'd4, 5'd8, 16'h8001, 16'h0002, 24'h000510, 24'h000514, 0, 0);
    step("R9", 1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h000514, 24'h000518, 0, 0);

    // R7: backward displacement and address wrap
    step("R7", 1, 3'd1, 5'd9, 16'h0000, 16'hFFFF, 24'h000010, 24'h000014, 0, 0);
    step("R9", 0, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h000014, 24'h000018, 0, 0);
    step("R9", 0, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h000014, 24'h000018, 0, 0);
    step("R9", 1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h000014, 24'h000018, 0, 0);
    step("R7", 1, 3'd1, 5'd9, 16'h0000, 16'h0008, 24'hFFFFF0, 24'hFFFFF4, 0, 0);
    step("R9", 1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'hFFFFF4, 24'hFFFFF8, 0, 0);
    step("R7", 1, 3'd2, 5'd9, 16'h0000, 16'h8000, 24'h020000, 24'h020004, 0, 0);
    step("R9", 1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h020004, 24'h020008, 0, 0);

    // R10 R11: dependence on the instruction ahead, held one cycle
    step("R10", 1, 3'd1, 5'd5, 16'h0000, 16'h0004, 24'h000600, 24'h000604, 1, 5'd5);
    step("R11", 1, 3'd1, 5'd5, 16'h0000, 16'h0004, 24'h000600, 24'h000604, 1, 5'd5);
    step("R9",  1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h000604, 24'h000608, 0, 0);
    step("R10", 1, 3'd4, 5'd3, 16'h0005, 16'h0004, 24'h000700, 24'h000704, 1, 5'd3);
    step("R11", 1, 3'd4, 5'd3, 16'h0005, 16'h0004, 24'h000700, 24'h000704, 1, 5'd3);
    step("R9",  1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h000704, 24'h000708, 0, 0);
    // no stall: different register, write disabled
    step("R10", 1, 3'd1, 5'd5, 16'h0000, 16'h0004, 24'h000800, 24'h000804, 1, 5'd6);
    step("R9",  1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h000804, 24'h000808, 0, 0);
    step("R10", 1, 3'd1, 5'd5, 16'h0000, 16'h0004, 24'h000808, 24'h00080C, 0, 5'd5);
    step("R9",  1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h00080C, 24'h000810, 0, 0);

    // R12: register 0 never stalls
    step("R12", 1, 3'd1, 5'd0, 16'h0000, 16'h0004, 24'h000900, 24'h000904, 1, 5'd0);
    step("R9",  1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h000904, 24'h000908, 0, 0);
    step("R6",  1, 3'd0, 5'd0, 16'h0000, 16'h0000, 24'h000908, 24'h00090C, 0, 0);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule